// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Boundary Flag

This block is a first-in first-out buffer of 2048 nine-bit words. The write port and the read port each have their own clock. The two clocks may be unrelated, or they may be the same net. The read port is show-ahead: the oldest unread word is already on `rd_data` whenever `nonempty` is high, so a read strobe only moves the buffer on to the next word. Status comes out on four flags: active-low full (`not_full`), active-low empty (`nonempty`), half-full, and a single near-boundary flag. The near-boundary flag covers both the low-water mark X and the high-water mark Y.

After reset, the thresholds are 256 each. While no data word has yet been stored, a write strobe taken with `thr_prog_n` low does not store anything. Instead it loads a 10-bit threshold built from `{thr_msb, wr_data}`. The first such strobe loads both X and Y. A second one loads Y only. The first real data write closes this programming window.

Each pointer crosses into the other clock domain as Gray code through a two-stage synchronizer. The full flag and the fill flags (half-full and near-boundary) are computed in the write domain. The empty flag is computed in the read domain. A change made by the local side shows on the flags one edge after that side's strobe. A change made by the other side shows three edges later, counted on the clock of the side that computes the flag, so the flags err on the safe side. Reset `rst` is active high and synchronous. It must stay high for at least two edges of each clock.

Top module: `fifo9_prog`

## Requirements
- R1: Words leave in the order they were written. While `nonempty` is 1 and `rd_oe` is 1, `rd_data` shows the oldest unread word without any read strobe.
- R2: A write strobe taken while `not_full` is 0 is dropped. `not_full` is 0 exactly when the write-side view of the occupancy equals 2048.
- R3: A read strobe taken while `nonempty` is 0 is dropped. `nonempty` is 0 exactly when the read-side view of the occupancy is zero.
- R4: `half_full` is 1 when the write-side occupancy is 1024 or more, and 0 when it is 1023 or less.
- R5: `near_edge` is 1 when the write-side occupancy is at most X, or at least 2048 − Y. It is 0 in between.
- R6: With no programming after reset, X = Y = 256.
- R7: The first write strobe after reset taken with `thr_prog_n` = 0 loads X and Y with `{thr_msb, wr_data}` (`thr_msb` is bit 9) and stores no word.
- R8: A second consecutive programming strobe loads Y only and stores no word. After two programming strobes, or after any data write, a strobe with `thr_prog_n` = 0 stores data as normal.
- R9: While `rd_oe` is 0, `rd_data` is all zeros. The flags do not depend on `rd_oe`.
- R10: During and right after reset, `not_full` = 1, `nonempty` = 0, `half_full` = 0 and `near_edge` = 1.
- R11: A local strobe at edge k shows on the local flags after edge k. The other side sees it after edge k+3 of its own clock. Each Gray pointer changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| wr_en | input | 1 | Write strobe, sampled on the rising edge of `wr_clk` |
| wr_data | input | 9 | Write word; also the low 9 bits of a threshold |
| thr_prog_n | input | 1 | Active-low threshold programming request |
| thr_msb | input | 1 | Bit 9 of a programmed threshold |
| rd_en | input | 1 | Read strobe, sampled on the rising edge of `rd_clk` |
| rd_oe | input | 1 | Data output enable; 0 forces `rd_data` to zero |
| rd_data | output | 9 | Oldest unread word (show-ahead) |
| not_full | output | 1 | Low when the buffer is full |
| nonempty | output | 1 | Low when the buffer is empty |
| half_full | output | 1 | High at 1024 or more words |
| near_edge | output | 1 | High at or below X, or at or above 2048 − Y |

## Verification
The bench drives both ports from one 200 MHz clock and keeps a behavioural queue model. The model delays each side's pointer by three edges before the other side uses it. Every flag and the data port are compared on every clock.

The stimulus falls into three groups:
- Pure fill runs that push past 2048 and pure drain runs that read past zero. These separate correct dropping of extra strobes from silent overwrite or underflow.
- Mixed random traffic at low and high fill, with `rd_oe` toggled at random. This shows whether the order is kept and the crossing latency is right while both pointers move on the same edge.
- Several reset-and-program sequences: none, one strobe, two strobes, and a late `thr_prog_n` after data. These tell apart the default thresholds, loading both thresholds, loading Y alone, and a closed programming window.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  // threshold programming window after reset
  typedef enum logic [1:0] {
    PRG_OPEN  = 2'd0,   // next programming strobe loads both thresholds
    PRG_YONLY = 2'd1,   // next programming strobe loads the high-water mark only
    PRG_DONE  = 2'd2    // window closed, strobes store data
  } prog_st_e;

  localparam int DEF_OFFSET = 256;
endpackage

// File: rtl/fifo9_gsync.sv
module fifo9_gsync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fifo9_ram.sv
module fifo9_ram #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo9_wr_side.sv
module fifo9_wr_side
  import fifo9_pkg::*;
#(
  parameter int AW      = 11,
  parameter int TW      = 10,
  parameter int DEF_OFS = DEF_OFFSET
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          thr_prog_n,
  input  logic [TW-1:0] prog_val,
  input  logic [AW:0]   rgray_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wgray,
  output logic          not_full,
  output logic          half_full,
  output logic          near_edge
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_nx, rbin_s, wcnt_nx, hi_lim;
  logic [TW-1:0] x_ofs, y_ofs;
  prog_st_e      pst;
  logic          prog_hit, data_hit;

  // Gray to binary for the synchronized read pointer
  always_comb begin
    rbin_s[PW-1] = rgray_sync[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_sync[i];
  end

  assign prog_hit  = wr_en && !thr_prog_n && (pst != PRG_DONE);
  assign data_hit  = wr_en && !prog_hit && not_full;
  assign wbin_nx   = wbin + PW'(data_hit);
  assign wcnt_nx   = wbin_nx - rbin_s;
  assign hi_lim    = PW'(DEPTH) - PW'(y_ofs);
  assign mem_we    = data_hit;
  assign mem_waddr = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin      <= '0;
      wgray     <= '0;
      not_full  <= 1'b1;
      half_full <= 1'b0;
      near_edge <= 1'b1;
      x_ofs     <= TW'(DEF_OFS);
      y_ofs     <= TW'(DEF_OFS);
      pst       <= PRG_OPEN;
    end else begin
      wbin      <= wbin_nx;
      wgray     <= wbin_nx ^ (wbin_nx >> 1);
      not_full  <= (wcnt_nx != PW'(DEPTH));
      half_full <= (wcnt_nx >= PW'(DEPTH / 2));
      near_edge <= (wcnt_nx <= PW'(x_ofs)) || (wcnt_nx >= hi_lim);
      if (prog_hit) begin
        if (pst == PRG_OPEN) begin
          x_ofs <= prog_val;
          y_ofs <= prog_val;
          pst   <= PRG_YONLY;
        end else begin
          y_ofs <= prog_val;
          pst   <= PRG_DONE;
        end
      end else if (data_hit) begin
        pst <= PRG_DONE;
      end
    end
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) (wr_en && !not_full) |=> $stable(wbin));  // R2
  AST_PROG_NO_STORE: assert property (@(posedge clk) disable iff (rst) (wr_en && !thr_prog_n && pst != PRG_DONE) |=> $stable(wbin));  // R7
  AST_FULL_HAS_HALF: assert property (@(posedge clk) disable iff (rst) !not_full |-> half_full);  // R4
  AST_FULL_IS_NEAR: assert property (@(posedge clk) disable iff (rst) !not_full |-> near_edge);  // R5
  AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (rst) $countones(wgray ^ $past(wgray)) <= 1);  // R11
endmodule

// File: rtl/fifo9_rd_side.sv
module fifo9_rd_side #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_sync,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          nonempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx, rgray_nx;
  logic          rd_hit;

  assign rd_hit   = rd_en && nonempty;
  assign rbin_nx  = rbin + PW'(rd_hit);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  // address the next head so the registered read shows it one edge later
  assign raddr    = rbin_nx[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      nonempty <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      nonempty <= (rgray_nx != wgray_sync);
    end
  end

  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst) (rd_en && !nonempty) |=> $stable(rbin));  // R3
  AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (rst) $countones(rgray ^ $past(rgray)) <= 1);  // R11
endmodule

// File: rtl/fifo9_prog.sv
module fifo9_prog
  import fifo9_pkg::*;
#(
  parameter int DW      = 9,
  parameter int AW      = 11,
  parameter int SYNC_ST = 2,
  parameter int DEF_OFS = DEF_OFFSET
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          thr_prog_n,
  input  logic          thr_msb,
  input  logic          rd_en,
  input  logic          rd_oe,
  output logic [DW-1:0] rd_data,
  output logic          not_full,
  output logic          nonempty,
  output logic          half_full,
  output logic          near_edge
);
  localparam int TW = DW + 1;
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, raddr;
  logic [DW-1:0] head;

  fifo9_wr_side #(.AW(AW), .TW(TW), .DEF_OFS(DEF_OFS)) u_wr (
    .clk        (wr_clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .thr_prog_n (thr_prog_n),
    .prog_val   ({thr_msb, wr_data}),
    .rgray_sync (rgray_s),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .wgray      (wgray),
    .not_full   (not_full),
    .half_full  (half_full),
    .near_edge  (near_edge)
  );

  fifo9_rd_side #(.AW(AW)) u_rd (
    .clk        (rd_clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .wgray_sync (wgray_s),
    .rgray      (rgray),
    .raddr      (raddr),
    .nonempty   (nonempty)
  );

  fifo9_gsync #(.W(PW), .STAGES(SYNC_ST)) u_sync_r2w (
    .clk (wr_clk), .rst (rst), .d (rgray), .q (rgray_s)
  );

  fifo9_gsync #(.W(PW), .STAGES(SYNC_ST)) u_sync_w2r (
    .clk (rd_clk), .rst (rst), .d (wgray), .q (wgray_s)
  );

  fifo9_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .rclk  (rd_clk),
    .raddr (raddr),
    .rdata (head)
  );

  assign rd_data = rd_oe ? head : '0;
endmodule

// File: tb/fifo9_prog_tb.sv
`timescale 1ns/1ps
module fifo9_prog_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, rd_oe = 1'b1;
  logic       thr_prog_n = 1'b1, thr_msb = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       not_full, nonempty, half_full, near_edge;

  always #2.5 clk = ~clk;

  fifo9_prog u_dut (
    .wr_clk (clk), .rd_clk (clk), .rst (rst),
    .wr_en (wr_en), .wr_data (wr_data), .thr_prog_n (thr_prog_n), .thr_msb (thr_msb),
    .rd_en (rd_en), .rd_oe (rd_oe), .rd_data (rd_data),
    .not_full (not_full), .nonempty (nonempty), .half_full (half_full), .near_edge (near_edge)
  );

  // reference model
  logic [8:0] mq[$];
  int wtot, rtot, xo, yo, stage;
  int wh[4], rh[4];
  bit e_nf = 1, e_ne = 0, e_hf = 0, e_near = 1;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string ph = "R10";

  task automatic chk(input int act, input int exp, input string req, input string sig);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s, phase %s) at %0t: actual %0d expected %0d", req, sig, ph, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk(not_full, e_nf, "R2", "not_full");
    chk(nonempty, e_ne, "R3", "nonempty");
    chk(half_full, e_hf, "R4", "half_full");
    chk(near_edge, e_near, "R5", "near_edge");
    if (!rd_oe) chk(rd_data, 0, "R9", "rd_data");
    else if (e_ne) chk(rd_data, mq[0], "R1", "rd_data");
  endtask

  task automatic step(input bit w, input bit r, input logic [8:0] d,
                      input bit pn, input bit m, input bit oe, input bit rs);
    bit aw, ar, ap;
    int wc;
    @(negedge clk);
    compare();
    rst = rs; wr_en = w; rd_en = r; wr_data = d; thr_prog_n = pn; thr_msb = m; rd_oe = oe;
    ap = !rs && w && !pn && stage != 2;
    aw = !rs && w && !ap && e_nf;
    ar = !rs && r && e_ne;
    @(posedge clk);
    if (rs) begin
      // R10: reset state
      mq.delete(); wtot = 0; rtot = 0; xo = 256; yo = 256; stage = 0;
      for (int i = 0; i < 4; i++) begin wh[i] = 0; rh[i] = 0; end
      e_nf = 1; e_ne = 0; e_hf = 0; e_near = 1;
    end else begin
      if (aw) mq.push_back(d);
      if (ar) void'(mq.pop_front());
      wtot += int'(aw); rtot += int'(ar);
      for (int i = 3; i > 0; i--) begin wh[i] = wh[i-1]; rh[i] = rh[i-1]; end
      wh[0] = wtot; rh[0] = rtot;
      // R11: local view now, remote view three edges late
      wc     = wh[0] - rh[3];
      e_nf   = (wc != 2048);
      e_hf   = (wc >= 1024);
      e_near = (wc <= xo) || (wc >= 2048 - yo);
      e_ne   = (wh[3] - rh[0]) != 0;
      if (ap) begin
        if (stage == 0) begin xo = {m, d}; yo = {m, d}; stage = 1; end  // R7
        else begin yo = {m, d}; stage = 2; end                           // R8
      end else if (aw) stage = 2;
    end
  endtask

  task automatic do_reset();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 1, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 1, 0);
  endtask

  task automatic mixed(input int n, input int pw, input int pr, input bit rand_oe);
    for (int i = 0; i < n; i++)
      step($urandom_range(99) < pw, $urandom_range(99) < pr, 9'($urandom),
           1, 0, rand_oe ? ($urandom_range(3) != 0) : 1'b1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ph = "R10"; do_reset();
    // R7 then R8: X=Y=5, then Y={1,10}=522, then late program request stores data
    ph = "R7"; step(1, 0, 9'd5, 0, 0, 1, 0);
    ph = "R8"; step(1, 0, 9'd10, 0, 1, 1, 0);
    step(1, 0, 9'h1AA, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 1, 0);
    // R2: fill beyond capacity
    ph = "R2";
    for (int i = 0; i < 2100; i++) step(1, 0, 9'(i * 7 + 3), 1, 0, 1, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 1, 0);
    // R3: drain beyond empty
    ph = "R3";
    for (int i = 0; i < 2100; i++) step(0, 1, 0, 1, 0, 1, 0);
    // R1, R9, R11: mixed traffic with output enable toggling
    ph = "R1"; mixed(6000, 55, 45, 1);
    ph = "R9"; mixed(3000, 50, 50, 1);
    // R6: defaults after a fresh reset
    ph = "R6"; do_reset();
    for (int i = 0; i < 1900; i++) step(1, 0, 9'(i), 1, 0, 1, 0);
    mixed(4000, 60, 45, 0);
    for (int i = 0; i < 1000; i++) step(0, 1, 0, 1, 0, 1, 0);
    mixed(3000, 40, 60, 0);
    // R8: program request after a data write stores data
    ph = "R8"; do_reset();
    step(1, 0, 9'h055, 1, 0, 1, 0);
    step(1, 0, 9'h0AA, 0, 1, 1, 0);
    step(1, 0, 9'h1FF, 0, 1, 1, 0);
    for (int i = 0; i < 8; i++) step(0, 1, 0, 1, 0, 1, 0);
    // R7: single programming strobe using the MSB, X=Y=512
    ph = "R7"; do_reset();
    step(1, 0, 9'd0, 0, 1, 1, 0);
    for (int i = 0; i < 1700; i++) step(1, 0, 9'(i ^ 9'h13), 1, 0, 1, 0);
    mixed(3000, 50, 50, 0);
    for (int i = 0; i < 2100; i++) step(0, 1, 0, 1, 0, 1, 0);
    ph = "R11"; mixed(2000, 70, 70, 0);
    step(0, 0, 0, 1, 0, 1, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule